// File: doc/BRIEF.md
# Stereo Digital Volume with Soft Mute

This block scales a stereo stream of signed PCM samples, such as the output of a decimation chain, by a separate gain for the left and the right channel. Each channel's gain comes from an 8-bit code. The codes cover +24 dB down to −63.5 dB in half-decibel steps. Every code above that range is a hard mute that forces the output to exact zero.

The same multiplier also provides a soft mute. A shared ramp level runs linearly between zero and full scale, and it moves one step on every accepted sample. Raising the mute request fades both channels out. Dropping it fades them back to their programmed gains. Because the ramp starts at zero after reset, the stream also fades in at power-up without a click.

A status output reports when the ramp has reached zero, so the front path can then be powered down safely. Codes and the mute request are read only on cycles that carry a sample. A change made between samples therefore never splits a sample across two gains.

Top module: `stereo_volume`

## Requirements
- R1: A code k from 0 to 175 selects the linear gain word G(k) = (M[k mod 12] · 16) >> floor(k/12), a fixed-point value with 16 fraction bits. M[r] = round(65536 · 2^(−r/12)), so each code step is about 0.5 dB. Code 0 gives about +24 dB and code 175 gives about −63.5 dB.
- R2: Any code from 176 to 255 is a hard mute. The output of that channel is exactly zero.
- R3: The left output depends only on the left sample and left code. The right output depends only on the right sample and right code. Both share the ramp level.
- R4: Each output equals floor((x · E + 32768) / 65536), which is x · E / 2^16 rounded half up. The result saturates to the signed DATA_W range. E is the effective gain of R7.
- R5: out_valid is high exactly two cycles after each cycle with in_valid high, and low otherwise. Between valid outputs, out_left and out_right hold their last values.
- R6: gain_left, gain_right and mute_req are read only in cycles where in_valid is high. Values they take in other cycles have no effect on any output.
- R7: A ramp level c lies in 0 to N, where N = 2^RAMP_LOG2 (16 by default). A sample uses E = (G · c) >> RAMP_LOG2, where c is the level before that sample. After each accepted sample, c moves one step toward 0 if mute_req is high, or toward N if it is low.
- R8: While rst_n is low, the ramp level is set to 0, out_valid is 0, both outputs are 0 and mute_done is 1.
- R9: mute_done is high exactly when the ramp level is 0. It updates on the clock edge that accepts a sample, so it is seen one cycle after in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| gain_left | input | 8 | Left gain code |
| gain_right | input | 8 | Right gain code |
| mute_req | input | 1 | Soft-mute request (high: fade out) |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | DATA_W | Scaled left sample, signed |
| out_right | output | DATA_W | Scaled right sample, signed |
| mute_done | output | 1 | Ramp level has reached zero |

## Verification
A wrong ramp level shows on the next valid output pair as a wrong magnitude on both channels at once, and one cycle earlier on mute_done. A wrong lookup entry or shift shows on the very next sample that uses that code, which is why the full code range is swept on both channels with mirrored codes. A rounding or saturation fault only shows for extreme or tiny samples, so those are driven on purpose. A code or mute request read outside a sample cycle shows as a mismatch on the following output, because the reference reads them only on strobe cycles.

// File: rtl/svm_pkg.sv
// Shared constants and the gain mantissa function for the stereo volume block.
// Assumes a 16-bit fractional gain word with 4 integer bits (up to x16, about +24 dB).
package svm_pkg;
    localparam int SVM_CODE_W    = 8;
    localparam int SVM_FRAC      = 16;
    localparam int SVM_HEAD      = 4;
    localparam int SVM_GAIN_W    = SVM_FRAC + SVM_HEAD + 1;
    localparam int SVM_LAST_CODE = 175;
    localparam int SVM_PER_OCT   = 12;
    localparam int SVM_CHANNELS  = 2;

    // round(65536 * 2^(-r/12)) for one octave of half-decibel steps
    function automatic logic [SVM_FRAC:0] svm_mantissa(input logic [SVM_CODE_W-1:0] r);
        logic [SVM_FRAC:0] m;
        case (r)
            8'd0:    m = 17'd65536;
            8'd1:    m = 17'd61858;
            8'd2:    m = 17'd58386;
            8'd3:    m = 17'd55109;
            8'd4:    m = 17'd52016;
            8'd5:    m = 17'd49097;
            8'd6:    m = 17'd46341;
            8'd7:    m = 17'd43740;
            8'd8:    m = 17'd41285;
            8'd9:    m = 17'd38968;
            8'd10:   m = 17'd36781;
            8'd11:   m = 17'd34716;
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/svm_gain_lut.sv
// Maps a gain code to a linear gain word: the mantissa for the step within an
// octave, shifted right by the octave count. Codes past the last step give zero.
// Assumes a purely combinational use; the caller registers the result.
module svm_gain_lut
    import svm_pkg::*;
(
    input  logic [SVM_CODE_W-1:0] code,
    output logic [SVM_GAIN_W-1:0] gain
);
    localparam logic [SVM_CODE_W-1:0] PER_OCT = SVM_CODE_W'(SVM_PER_OCT);
    localparam logic [SVM_CODE_W-1:0] LAST    = SVM_CODE_W'(SVM_LAST_CODE);

    logic [SVM_CODE_W-1:0] octave;
    logic [SVM_CODE_W-1:0] step;
    logic [SVM_GAIN_W-1:0] top_word;

    // Split the code into octave and step, then scale the mantissa
    always_comb begin
        octave   = code / PER_OCT;
        step     = code % PER_OCT;
        top_word = {svm_mantissa(step), {SVM_HEAD{1'b0}}};
        if (code > LAST) gain = '0;
        else             gain = top_word >> octave;
    end
endmodule

// File: rtl/svm_ramp.sv
// Shared linear soft-mute ramp. The level moves one step per accepted sample:
// down toward zero while mute is requested, up toward full scale otherwise.
// Assumes mute_req is only meaningful when take is high. Resets to zero (faded out).
module svm_ramp #(
    parameter int RAMP_LOG2 = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               mute_req,
    output logic [RAMP_LOG2:0] level,
    output logic               muted
);
    localparam logic [RAMP_LOG2:0] FULL = {1'b1, {RAMP_LOG2{1'b0}}};
    localparam logic [RAMP_LOG2:0] ONE  = {{RAMP_LOG2{1'b0}}, 1'b1};

    logic [RAMP_LOG2:0] level_n;
    logic               live;

    // Next level for the sample being accepted
    always_comb begin
        level_n = level;
        if (mute_req) begin
            if (level != '0) level_n = level - ONE;
        end else begin
            if (level != FULL) level_n = level + ONE;
        end
    end

    // Level and zero flag advance only on a sample boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            muted <= 1'b1;
        end else if (take) begin
            level <= level_n;
            muted <= (level_n == '0);
        end
    end

    // Marks cycles whose previous cycle was out of reset (for $past use)
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R7
    ramp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);

    // R7
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(take)) |-> $stable(level));

    // R9
    mute_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        muted |-> (level == '0));
endmodule

// File: rtl/svm_channel.sv
// One channel of the volume path. Stage 1 latches the sample and the effective
// gain (code gain times ramp level). Stage 2 multiplies, rounds half up and
// saturates. Assumes stage_valid is the take strobe delayed by one cycle.
module svm_channel
    import svm_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic                     stage_valid,
    input  logic signed [DATA_W-1:0] sample_in,
    input  logic [SVM_CODE_W-1:0]    code_in,
    input  logic [RAMP_LOG2:0]       level_in,
    output logic signed [DATA_W-1:0] result
);
    localparam int SCALE_W = SVM_GAIN_W + RAMP_LOG2 + 1;
    localparam int PROD_W  = DATA_W + SVM_GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] RND_HALF = PROD_W'(1) <<< (SVM_FRAC - 1);
    localparam logic signed [PROD_W-1:0] MAX_V    = (PROD_W'(1) <<< (DATA_W - 1)) - PROD_W'(1);
    localparam logic signed [PROD_W-1:0] MIN_V    = -(PROD_W'(1) <<< (DATA_W - 1));

    logic [SVM_GAIN_W-1:0]    code_gain;
    logic [SCALE_W-1:0]       scaled;
    logic [SVM_GAIN_W-1:0]    eff_gain;
    logic signed [DATA_W-1:0] s_smp;
    logic [SVM_GAIN_W-1:0]    s_eff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rounded;
    logic signed [DATA_W-1:0] clipped;

    svm_gain_lut u_lut (
        .code (code_in),
        .gain (code_gain)
    );

    // Apply the ramp level to the code gain
    always_comb begin
        scaled   = SCALE_W'(code_gain) * SCALE_W'(level_in);
        eff_gain = SVM_GAIN_W'(scaled >> RAMP_LOG2);
    end

    // Stage 1: hold sample and gain together so one sample sees one gain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_smp <= '0;
            s_eff <= '0;
        end else if (take) begin
            s_smp <= sample_in;
            s_eff <= eff_gain;
        end
    end

    // Multiply, round half up, then clamp to the output range
    always_comb begin
        prod    = PROD_W'(s_smp) * $signed({1'b0, s_eff});
        rounded = (prod + RND_HALF) >>> SVM_FRAC;
        if (rounded > MAX_V)      clipped = MAX_V[DATA_W-1:0];
        else if (rounded < MIN_V) clipped = MIN_V[DATA_W-1:0];
        else                      clipped = rounded[DATA_W-1:0];
    end

    // Stage 2: output register, held between valid samples
    always_ff @(posedge clk) begin
        if (!rst_n)           result <= '0;
        else if (stage_valid) result <= clipped;
    end

    // R2
    mute_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_valid && s_eff == '0) |=> (result == '0));
endmodule

// File: rtl/stereo_volume.sv
// Stereo digital volume with linear soft mute. Two channel slices share one
// ramp; codes and mute request are read on sample strobes only. Latency is
// two cycles from in_valid to out_valid. Assumes a synchronous active-low reset.
module stereo_volume
    import svm_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic [SVM_CODE_W-1:0]    gain_left,
    input  logic [SVM_CODE_W-1:0]    gain_right,
    input  logic                     mute_req,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right,
    output logic                     mute_done
);
    logic [RAMP_LOG2:0]       level;
    logic                     v1;
    logic signed [DATA_W-1:0] smp_in  [SVM_CHANNELS];
    logic [SVM_CODE_W-1:0]    code_in [SVM_CHANNELS];
    logic signed [DATA_W-1:0] res     [SVM_CHANNELS];

    // Gather per-channel inputs into arrays for the slice generator
    always_comb begin
        smp_in[0]  = in_left;
        smp_in[1]  = in_right;
        code_in[0] = gain_left;
        code_in[1] = gain_right;
    end

    svm_ramp #(.RAMP_LOG2(RAMP_LOG2)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (in_valid),
        .mute_req (mute_req),
        .level    (level),
        .muted    (mute_done)
    );

    // Valid pipeline matching the two data stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            out_valid <= v1;
        end
    end

    for (genvar ch = 0; ch < SVM_CHANNELS; ch++) begin : g_ch
        svm_channel #(
            .DATA_W    (DATA_W),
            .RAMP_LOG2 (RAMP_LOG2)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .take        (in_valid),
            .stage_valid (v1),
            .sample_in   (smp_in[ch]),
            .code_in     (code_in[ch]),
            .level_in    (level),
            .result      (res[ch])
        );
    end

    assign out_left  = res[0];
    assign out_right = res[1];

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R9
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_done && in_valid) |-> ##2 (out_left == '0 && out_right == '0));
endmodule

// File: tb/stereo_volume_test.sv
// Self-checking bench: a behavioural reference model advanced on each rising
// edge and compared against the outputs on each falling edge.
module stereo_volume_test;
    localparam int DW = 24;
    localparam int RL = 4;
    localparam int NFULL = 1 << RL;
    localparam longint MAXV = (64'sd1 <<< (DW - 1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (DW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_left = '0;
    logic signed [DW-1:0] in_right = '0;
    logic [7:0] gain_left = '0;
    logic [7:0] gain_right = '0;
    logic mute_req = 1'b0;
    logic out_valid;
    logic signed [DW-1:0] out_left;
    logic signed [DW-1:0] out_right;
    logic mute_done;

    stereo_volume #(.DATA_W(DW), .RAMP_LOG2(RL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .gain_left(gain_left), .gain_right(gain_right),
        .mute_req(mute_req), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .mute_done(mute_done)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;
    string phase_req = "R8";
    logic [31:0] lcg = 32'h1234_5678;

    int mant [12];
    int lvl;
    bit m1_v, m2_v, md;
    longint m1_xl, m1_xr, m1_gl, m1_gr, ol, orr;

    initial begin
        for (int r = 0; r < 12; r++)
            mant[r] = int'($floor(65536.0 * $pow(2.0, -real'(r) / 12.0) + 0.5));
    end

    function automatic longint gain_of(int k);
        if (k > 175) return 0;
        return longint'((mant[k % 12] * 16) >> (k / 12));
    endfunction

    function automatic longint scale(longint x, longint g);
        longint p;
        p = (x * g + 32768) >>> 16;
        if (p > MAXV) p = MAXV;
        if (p < MINV) p = MINV;
        return p;
    endfunction

    function automatic int rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return int'(lcg[31:8]);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: advances with each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            lvl = 0; m1_v = 0; m2_v = 0; ol = 0; orr = 0; md = 1;
        end else begin
            m2_v = m1_v;
            if (m1_v) begin
                ol  = scale(m1_xl, m1_gl);
                orr = scale(m1_xr, m1_gr);
            end
            m1_v = in_valid;
            if (in_valid) begin
                m1_xl = longint'(in_left);
                m1_xr = longint'(in_right);
                m1_gl = (gain_of(int'(gain_left)) * lvl) >> RL;
                m1_gr = (gain_of(int'(gain_right)) * lvl) >> RL;
                if (mute_req) begin
                    if (lvl > 0) lvl = lvl - 1;
                end else begin
                    if (lvl < NFULL) lvl = lvl + 1;
                end
                md = (lvl == 0);
            end
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R5", "out_valid", longint'(out_valid), longint'(m2_v));
            chk("R9", "mute_done", longint'(mute_done), longint'(md));
            if (m2_v) begin
                chk(phase_req, "out_left", longint'(out_left), ol);
                chk(phase_req, "out_right", longint'(out_right), orr);
            end
        end
    end

    task automatic put(int xl, int xr, int cl, int cr, bit m);
        in_valid   = 1'b1;
        in_left    = DW'(xl);
        in_right   = DW'(xr);
        gain_left  = 8'(cl);
        gain_right = 8'(cr);
        mute_req   = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Idle cycles with scrambled codes and mute request (R6)
    task automatic gap(int n);
        for (int i = 0; i < n; i++) begin
            in_valid   = 1'b0;
            gain_left  = 8'(rnd());
            gain_right = 8'(rnd());
            mute_req   = rnd() % 2 == 0;
            in_left    = DW'(rnd());
            in_right   = DW'(rnd());
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", "reset out_valid", longint'(out_valid), 0);
        chk("R8", "reset out_left", longint'(out_left), 0);
        chk("R8", "reset out_right", longint'(out_right), 0);
        chk("R8", "reset mute_done", longint'(mute_done), 1);
        rst_n = 1'b1;

        phase_req = "R7";          // fade-in after reset
        for (int i = 0; i < 20; i++) put(1000 + i, -1000 - i, 24, 24, 1'b0);

        phase_req = "R1";          // full code sweep, mirrored
        for (int k = 0; k <= 175; k++) put(100000, -77777, k, 175 - k, 1'b0);

        phase_req = "R2";          // hard-mute codes
        put(5000000, -5000000, 176, 255, 1'b0);
        put(-3000000, 3000000, 255, 176, 1'b0);
        put(8388607, 123, 200, 0, 1'b0);

        phase_req = "R3";          // independent channels, random codes and gaps
        for (int i = 0; i < 200; i++) begin
            put(rnd(), rnd(), rnd() % 256, rnd() % 256, 1'b0);
            if (i % 7 == 3) gap(2);
        end

        phase_req = "R4";          // saturation and rounding
        put(8388607, -8388608, 0, 0, 1'b0);
        put(-8388608, 8388607, 0, 0, 1'b0);
        for (int k = 170; k <= 175; k++) put(k - 172, 172 - k, k, 175, 1'b0);
        put(3, -3, 12, 12, 1'b0);
        put(-32768, 32767, 36, 36, 1'b0);

        phase_req = "R6";          // inputs changing between samples
        for (int i = 0; i < 30; i++) begin
            put(rnd(), rnd(), 10 + i, 40 + i, 1'b0);
            gap(1 + i % 3);
        end

        phase_req = "R9";          // fade out to mute_done
        for (int i = 0; i < 20; i++) put(200000, -200000, 6, 30, 1'b1);
        phase_req = "R7";          // fade back in, then reversal mid-ramp
        for (int i = 0; i < 20; i++) put(200000, -200000, 6, 30, 1'b0);
        for (int i = 0; i < 5; i++)  put(300000, 300000, 0, 12, 1'b1);
        for (int i = 0; i < 3; i++)  put(300000, 300000, 0, 12, 1'b0);
        gap(4);
        finish_run();
    end
endmodule